// File: doc/BRIEF.md
# Bank-Set Write-to-Read Command Gate

This block sits in a memory controller in front of a DRAM whose banks form two independent groups: the even set and the odd set. Column commands arrive one at a time with a valid/ready handshake. Each command carries a read/write flag, a bank address and a column address. The gate passes each command to a registered command output only once every spacing rule holds. Commands leave in arrival order. A command that is not yet legal holds `in_ready` low, and everything queued behind it waits.

Each set has its own internal data path, so the write-to-read turnaround depends on the set a read targets. A read to a set that was written recently waits the full turnaround. A read to the other set may go after a shorter delay. The gate keeps a saturating elapsed-cycle counter for the column spacing, and one per bank set for the time since the last write to that set. A read is legal when both per-set counters meet their thresholds.

Top module: `bankset_wr_gate`

## Requirements
- R1: The bank set of a command is bit 0 of its bank address (0 = even set, 1 = odd set). Each issued command appears on the output with `out_bus_sel` equal to that bit.
- R2: Two issued commands (handshake cycles) of any type are at least T_CC cycles apart, and a command that waits only on this rule issues exactly T_CC cycles after the previous one.
- R3: A read to the set of an earlier write issues no earlier than T_WR cycles after that write. It issues exactly then when nothing else delays it.
- R4: A read to the set opposite a write may issue T_WR_D cycles after that write (T_WR_D < T_WR). It issues exactly then when nothing else delays it.
- R5: A run of reads to any mix of banks, all in the set opposite the last write, issues early: the first read at T_WR_D after the write, then one every T_CC.
- R6: A read to the written set that follows early reads to the other set still waits until T_WR cycles after the write.
- R7: Writes are gated only by the T_CC spacing and are never delayed by earlier reads or writes beyond it.
- R8: Commands issue strictly in order. While the head command is illegal, `in_ready` is low. An issued command appears with unchanged flag, bank and column on the output, with `out_valid` high, in the cycle after its handshake.
- R9: During reset `out_valid` is low. Right after reset `in_ready` is high and a read issues without stalling.
- R10: The parameters obey T_CC >= 1 and T_WR >= T_WR_D >= T_CC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head command present |
| in_ready | output | 1 | Head command is legal and is taken this cycle |
| in_is_wr | input | 1 | 1 = write column command, 0 = read |
| in_bank | input | BANK_W | Bank address; bit 0 selects the set |
| in_col | input | COL_W | Column address |
| out_valid | output | 1 | Issued command present (one cycle) |
| out_is_wr | output | 1 | Issued command type |
| out_bank | output | BANK_W | Issued bank address |
| out_col | output | COL_W | Issued column address |
| out_bus_sel | output | 1 | Internal data path select, equal to the set bit |

## Verification
Assertions check on every cycle that no handshake breaks the column spacing or either turnaround threshold. They also check that every handshake yields an output pulse in the next cycle, that the bus select matches the bank set, and that the counters stay within their saturation value. The assertions cannot show that the gate is not too conservative. The bench scenarios show this by predicting the exact issue cycle of each command: same-set reads, opposite-set read bursts, a same-set read after such a burst, and writes back to back. They also show that stalls happen only where the rules demand them.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
    localparam int NUM_SETS = 2;

    typedef enum logic {
        SET_EVEN = 1'b0,
        SET_ODD  = 1'b1
    } bank_set_e;
endpackage

// File: rtl/bsg_elapsed_ctr.sv
module bsg_elapsed_ctr #(
    parameter int SAT = 8,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] elapsed
);
    localparam logic [W-1:0] SAT_L = W'(SAT);
    localparam logic [W-1:0] ONE_L = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = ONE_L;
        else if (cnt_q < SAT_L)
            cnt_d = cnt_q + ONE_L;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= SAT_L;
        else
            cnt_q <= cnt_d;
    end

    assign elapsed = cnt_q;

    // Counter never passes its saturation value (R2, R3)
    assert_sat_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_L);
endmodule

// File: rtl/bsg_issue_check.sv
module bsg_issue_check
    import bsg_pkg::*;
#(
    parameter int W      = 4,
    parameter int T_CC   = 2,
    parameter int T_WR   = 8,
    parameter int T_WR_D = 4
) (
    input  logic                     is_wr,
    input  logic                     set_bit,
    input  logic [W-1:0]             cc_elapsed,
    input  logic [NUM_SETS-1:0][W-1:0] wr_elapsed,
    output bank_set_e                head_set,
    output logic                     ready
);
    localparam logic [W-1:0] CC_L  = W'(T_CC);
    localparam logic [W-1:0] WR_L  = W'(T_WR);
    localparam logic [W-1:0] WRD_L = W'(T_WR_D);

    bank_set_e other_set;
    logic      cc_ok, same_ok, other_ok;

    always_comb begin
        head_set  = bank_set_e'(set_bit);
        other_set = bank_set_e'(~set_bit);
        cc_ok     = cc_elapsed >= CC_L;
        same_ok   = wr_elapsed[head_set] >= WR_L;
        other_ok  = wr_elapsed[other_set] >= WRD_L;
        ready     = cc_ok && (is_wr || (same_ok && other_ok));
    end
endmodule

// File: rtl/bankset_wr_gate.sv
module bankset_wr_gate
    import bsg_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 8,
    parameter int T_CC   = 2,
    parameter int T_WR   = 8,
    parameter int T_WR_D = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_wr,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    output logic              out_valid,
    output logic              out_is_wr,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col,
    output logic              out_bus_sel
);
    localparam int SAT   = T_WR;
    localparam int CNT_W = $clog2(SAT + 1);

    typedef struct packed {
        logic              valid;
        logic              is_wr;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              bus_sel;
    } out_cmd_t;

    out_cmd_t st_d, st_q;

    logic                          issue;
    logic                          head_ready;
    bank_set_e                     head_set;
    logic [CNT_W-1:0]              cc_elapsed;
    logic [NUM_SETS-1:0][CNT_W-1:0] wr_elapsed;
    logic [NUM_SETS-1:0]           wr_restart;

    // Column spacing timer, restarted by every issued command
    bsg_elapsed_ctr #(.SAT(SAT), .W(CNT_W)) u_cc_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (issue),
        .elapsed (cc_elapsed)
    );

    // One write timer per bank set
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        assign wr_restart[s] = issue && in_is_wr && (in_bank[0] == 1'(s));

        bsg_elapsed_ctr #(.SAT(SAT), .W(CNT_W)) u_wr_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (wr_restart[s]),
            .elapsed (wr_elapsed[s])
        );
    end

    bsg_issue_check #(
        .W(CNT_W), .T_CC(T_CC), .T_WR(T_WR), .T_WR_D(T_WR_D)
    ) u_check (
        .is_wr      (in_is_wr),
        .set_bit    (in_bank[0]),
        .cc_elapsed (cc_elapsed),
        .wr_elapsed (wr_elapsed),
        .head_set   (head_set),
        .ready      (head_ready)
    );

    assign in_ready = head_ready;
    assign issue    = in_valid && head_ready;

    always_comb begin
        st_d       = st_q;
        st_d.valid = issue;
        if (issue) begin
            st_d.is_wr   = in_is_wr;
            st_d.bank    = in_bank;
            st_d.col     = in_col;
            st_d.bus_sel = logic'(head_set);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_is_wr   = st_q.is_wr;
    assign out_bank    = st_q.bank;
    assign out_col     = st_q.col;
    assign out_bus_sel = st_q.bus_sel;

    // Parameter ordering (R10)
    initial begin
        assert_param_order_R10: assert (T_CC >= 1 && T_WR_D >= T_CC && T_WR >= T_WR_D)
            else $error("bad timing parameter order");
    end

    assert_cc_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> cc_elapsed >= CNT_W'(T_CC));

    assert_same_set_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !in_is_wr) |-> wr_elapsed[in_bank[0]] >= CNT_W'(T_WR));

    assert_other_set_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !in_is_wr) |-> wr_elapsed[~in_bank[0]] >= CNT_W'(T_WR_D));

    assert_out_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (out_valid && out_bank == $past(in_bank) && out_col == $past(in_col)));

    assert_bus_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_bus_sel == out_bank[0]);
endmodule

// File: tb/bankset_wr_gate_bench.sv
`timescale 1ns/1ps
module bankset_wr_gate_bench;
    localparam int BANK_W = 3;
    localparam int COL_W  = 8;
    localparam int T_CC   = 2;
    localparam int T_WR   = 8;
    localparam int T_WR_D = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic              in_is_wr;
    logic [BANK_W-1:0] in_bank;
    logic [COL_W-1:0]  in_col;
    logic              out_valid;
    logic              out_is_wr;
    logic [BANK_W-1:0] out_bank;
    logic [COL_W-1:0]  out_col;
    logic              out_bus_sel;

    bankset_wr_gate #(
        .BANK_W(BANK_W), .COL_W(COL_W), .T_CC(T_CC), .T_WR(T_WR), .T_WR_D(T_WR_D)
    ) u_bankset_wr_gate (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_wr(in_is_wr),
        .in_bank(in_bank), .in_col(in_col),
        .out_valid(out_valid), .out_is_wr(out_is_wr), .out_bank(out_bank),
        .out_col(out_col), .out_bus_sel(out_bus_sel)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0;
    int checks = 0;
    int last_iss = -1000;
    int last_wr [2] = '{-1000, -1000};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Starts and ends at a falling edge (+1ns); logs issue cycle, checks it and the output
    task automatic send(input bit wr, input int bank, input int col, input string req);
        int earliest, exp, t, s;
        bit stalled;
        earliest = cyc;
        exp = imax(earliest, last_iss + T_CC);
        s = bank & 1;
        if (!wr) begin
            exp = imax(exp, last_wr[s] + T_WR);
            exp = imax(exp, last_wr[1-s] + T_WR_D);
        end
        in_valid = 1'b1;
        in_is_wr = wr;
        in_bank  = BANK_W'(bank);
        in_col   = COL_W'(col);
        #1;
        stalled = 1'b0;
        while (!in_ready) begin
            stalled = 1'b1;
            @(negedge clk); #1;
        end
        @(posedge clk);
        t = cyc;
        $display("issue %s bank=%0d col=%0d at cycle %0d", wr ? "WR" : "RD", bank, col, t);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(t == exp, req, "issue cycle", t, exp);
        if (exp > earliest)
            chk(stalled, "R8", "ready held low while head illegal", stalled, 1);
        chk(out_valid && out_is_wr == wr && out_bank == BANK_W'(bank) && out_col == COL_W'(col),
            "R8", "output fields", int'(out_bank), bank);
        chk(out_bus_sel == bank[0], "R1", "bus select", out_bus_sel, bank & 1);
        last_iss = t;
        if (wr) last_wr[s] = t;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_is_wr = 1'b0; in_bank = '0; in_col = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_is_wr = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R9", "ready after reset", in_ready, 1);
        send(1'b0, 6, 17, "R9");
        idle(T_WR + 2);
    endtask

    task automatic t_same_set;
        send(1'b1, 2, 10, "R7");
        send(1'b0, 4, 11, "R3");
        idle(T_WR + 2);
        send(1'b1, 3, 12, "R7");
        send(1'b0, 7, 13, "R3");
        idle(T_WR + 2);
    endtask

    task automatic t_opposite;
        send(1'b1, 2, 20, "R7");
        send(1'b0, 1, 21, "R4");
        send(1'b0, 3, 22, "R5");
        send(1'b0, 0, 23, "R6");
        idle(T_WR + 2);
    endtask

    task automatic t_burst;
        send(1'b1, 5, 30, "R7");
        send(1'b0, 0, 31, "R5");
        send(1'b0, 2, 32, "R5");
        send(1'b0, 4, 33, "R5");
        send(1'b0, 6, 34, "R5");
        send(1'b0, 7, 35, "R6");
        idle(T_WR + 2);
    endtask

    task automatic t_writes;
        send(1'b1, 1, 40, "R2");
        send(1'b1, 2, 41, "R2");
        send(1'b0, 3, 42, "R3");
        send(1'b1, 0, 43, "R7");
        send(1'b1, 4, 44, "R2");
        idle(T_WR + 2);
    endtask

    initial begin
        chk(T_CC >= 1 && T_WR_D >= T_CC && T_WR >= T_WR_D, "R10", "parameter order", T_WR_D, T_CC);
        t_reset;
        t_same_set;
        t_opposite;
        t_burst;
        t_writes;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #100000;
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule